// File: doc/BRIEF.md
# Block-Transfer DMA Controller

This controller copies a block of words between a peripheral and memory while the processor does other work. Software sets a start address and a word count through a small slave port, then writes a control word. That control word picks the direction and the bus-ownership mode, and carries a GO bit. The controller asks for the bus, waits until it is granted and then moves one word in each cycle in which the peripheral requests service. For every word it acknowledges the peripheral and strobes memory.

There are two ownership modes. In burst mode the bus is held from the first word to the last. In cycle-stealing mode the bus request is dropped for one cycle after every word except the final one, which hands the bus back to the processor between words. The address register counts up and the count register counts down. When the count reaches zero the block is finished: the request is withdrawn and an interrupt is raised, and the interrupt stays up until software writes the control register again. Data is not stored in the controller. It passes straight from the peripheral to memory, or from memory to the peripheral, in the cycle of the strobe.

Top module: `blk_dma`

## Requirements
- R1: Register index 0 holds the memory address, index 1 the word count and index 2 control. A control write uses bit 0 as GO, bit 1 as direction (1 = memory to peripheral through memory reads, 0 = peripheral to memory through memory writes) and bit 2 as mode (1 = cycle stealing, 0 = burst). Status read at index 2 returns bit 0 busy, bit 1 direction, bit 2 mode and bit 3 done. Index 3 reads zero. `reg_rdata` is zero whenever no read is selected.
- R2: A GO with a nonzero count raises `bus_req` in the following cycle. No memory strobe or `dev_ack` appears before `bus_grant` is high.
- R3: The address register goes up by one after each word moved, and memory outside the block is left untouched.
- R4: The count register goes down by one after each word and reads zero once the block is done.
- R5: `mem_rd`, `mem_wr` and `dev_ack` are high only while both `bus_req` and `bus_grant` are high. `mem_addr` is zero whenever the bus is not owned.
- R6: In burst mode `bus_req` rises once and stays high for the whole block. A word is moved in each owned cycle in which `dev_req` is high.
- R7: In cycle-stealing mode, after each word that is not the last, `bus_req` is low for exactly one cycle and is then raised again. A block of N words therefore has N bus tenures.
- R8: A word moves only in a cycle in which `dev_req` is high, and `dev_ack` is high in that same cycle. The direction picks `mem_rd` or `mem_wr`, and the data passes through unchanged.
- R9: `irq` rises in the cycle after the final word. It then stays high until a control write.
- R10: `bus_req` is low in the cycle after the final word.
- R11: A GO with a word count of zero sets `irq` in the next cycle and never raises `bus_req`.
- R12: Register writes made while busy are ignored.
- R13: After reset, `bus_req`, `irq`, the strobes and `dev_ack` are low, and the address, count and status registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Slave port select |
| reg_idx | input | 2 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Data to memory |
| mem_rdata | input | DW | Data from memory |
| dev_req | input | 1 | Peripheral service request |
| dev_ack | output | 1 | Peripheral acknowledge, one per word |
| dev_din | input | DW | Data from peripheral |
| dev_dout | output | DW | Data to peripheral |
| irq | output | 1 | Block-complete interrupt |

## Verification
The bench goes after the edges of the block. The first is the final word. A count test that is off by one would move one word too many, corrupting memory just past the block, or would leave `bus_req` high for a cycle after the last acknowledge. The second is the mode split. A design that mixed up the modes would show one tenure where N are expected in cycle-stealing mode, or gaps in `bus_req` during a burst. The third is a zero count, which a naive design would treat as a block of 2^CW words. The fourth is a register write while the grant is withheld, which a design lacking the busy guard would let retarget a transfer already in flight. A peripheral that pauses `dev_req` every other cycle checks that no word moves without a request.

// File: rtl/blk_dma.sv
module blk_dma #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic [1:0]    reg_idx,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_req,
  output logic          dev_ack,
  input  logic [DW-1:0] dev_din,
  output logic [DW-1:0] dev_dout,
  output logic          irq
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_MOVE, S_GAP} st_t;

  st_t           state;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  logic          dir_q, steal_q, irq_q;

  logic wr_en, busy, go_wr, xfer, last, own;

  assign wr_en = reg_sel & reg_wr;
  assign busy  = state != S_IDLE;
  assign go_wr = wr_en && reg_idx == 2'd2 && !busy && reg_wdata[0];
  assign own   = state == S_MOVE && bus_grant;
  assign xfer  = own && dev_req;
  assign last  = count_q == CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      count_q <= '0;
      dir_q   <= 1'b0;
      steal_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (wr_en) begin
          case (reg_idx)
            2'd0: addr_q  <= reg_wdata[AW-1:0];
            2'd1: count_q <= reg_wdata[CW-1:0];
            2'd2: begin
              dir_q   <= reg_wdata[1];
              steal_q <= reg_wdata[2];
              irq_q   <= 1'b0;
              if (reg_wdata[0]) begin
                if (count_q == '0) irq_q <= 1'b1;
                else               state <= S_REQ;
              end
            end
            default: ;
          endcase
        end
        S_REQ: if (bus_grant) state <= S_MOVE;
        S_MOVE: if (xfer) begin
          addr_q  <= addr_q + AW'(1);
          count_q <= count_q - CW'(1);
          if (last) begin
            state <= S_IDLE;
            irq_q <= 1'b1;
          end else if (steal_q) begin
            state <= S_GAP;
          end
        end
        S_GAP: state <= S_REQ;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_req   = state == S_REQ || state == S_MOVE;
  assign mem_addr  = own ? addr_q : '0;
  assign mem_rd    = xfer & dir_q;
  assign mem_wr    = xfer & ~dir_q;
  assign dev_ack   = xfer;
  assign mem_wdata = mem_wr ? dev_din : '0;
  assign dev_dout  = mem_rd ? mem_rdata : '0;
  assign irq       = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && reg_rd) begin
      case (reg_idx)
        2'd0: reg_rdata = DW'(addr_q);
        2'd1: reg_rdata = DW'(count_q);
        2'd2: reg_rdata = DW'({irq_q, steal_q, dir_q, busy});
        default: reg_rdata = '0;
      endcase
    end
  end

  assert_strobe_needs_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || dev_ack) |-> (bus_grant && bus_req));

  assert_ack_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> dev_req);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> addr_q == $past(addr_q) + AW'(1));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> count_q == $past(count_q) - CW'(1));

  assert_last_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && last) |=> (!bus_req && irq));

  assert_steal_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !last && steal_q) |=> !bus_req ##1 bus_req);

  assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && reg_idx == 2'd2)) |=> irq);

  assert_zero_go_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && count_q == '0) |=> (irq && !bus_req));

  assert_busy_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && reg_idx == 2'd0 && !xfer) |=> addr_q == $past(addr_q));
endmodule

// File: tb/blk_dma_test.sv
module blk_dma_test;
  localparam int AW = 16, CW = 16, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 0, reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_idx = 0;
  logic [DW-1:0] reg_wdata = 0, reg_rdata;
  logic bus_req, bus_grant, mem_rd, mem_wr, dev_ack, irq;
  logic dev_req = 0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_din, dev_dout;

  logic allow_grant = 1, mem_load = 0, dev_clr = 0;
  logic [DW-1:0] mem [64];
  logic [DW-1:0] sink [64];
  int dev_idx;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  blk_dma #(.AW(AW), .CW(CW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_idx(reg_idx),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_din(dev_din), .dev_dout(dev_dout),
    .irq(irq));

  assign mem_rdata = mem[mem_addr[5:0]];
  assign dev_din   = DW'(16'hA000 + dev_idx);

  always @(posedge clk) begin
    if (!rst_n) bus_grant <= 1'b0;
    else        bus_grant <= bus_req & allow_grant;
    if (mem_load) begin
      for (int i = 0; i < 64; i++) mem[i] <= DW'(16'h5000 + i);
    end else if (mem_wr) begin
      mem[mem_addr[5:0]] <= mem_wdata;
    end
    if (dev_clr) dev_idx <= 0;
    else if (dev_ack) begin
      sink[dev_idx[5:0]] <= dev_dout;
      dev_idx <= dev_idx + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] idx, input logic [DW-1:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic cfg_read(input logic [1:0] idx, output logic [DW-1:0] d);
    @(negedge clk);
    reg_sel = 1; reg_rd = 1; reg_idx = idx;
    #1 d = reg_rdata;
    reg_sel = 0; reg_rd = 0;
  endtask

  localparam int NV = 5;
  localparam int V_START [NV] = '{4, 10, 20, 33, 50};
  localparam int V_CNT   [NV] = '{5, 4, 3, 6, 1};
  localparam bit V_DIR   [NV] = '{0, 1, 0, 1, 0};
  localparam bit V_STEAL [NV] = '{0, 0, 1, 1, 1};
  localparam bit V_GAP   [NV] = '{0, 1, 0, 1, 0};

  task automatic run_vec(input int start, input int n, input bit dir, input bit steal, input bit gap);
    logic [DW-1:0] rv;
    int acks = 0, lows = 0, tenures = 0;
    bit prev_br = 0, pend = 0, fin = 0, bad = 0, first_ok = 0;
    allow_grant = 1;
    @(negedge clk); mem_load = 1; dev_clr = 1;
    @(negedge clk); mem_load = 0; dev_clr = 0;
    cfg_write(2'd0, DW'(start));
    cfg_write(2'd1, DW'(n));
    cfg_write(2'd2, DW'({steal, dir, 1'b1}));
    for (int cyc = 0; cyc < 300 && !fin; cyc++) begin
      dev_req = gap ? (cyc % 2 == 0) : 1'b1;
      #1;
      if (pend) begin
        chk(irq && !bus_req, "R9/R10 irq up, bus_req down after final word", {irq, bus_req}, 2'b10);
        fin = 1;
      end else begin
        if (cyc == 0) first_ok = bus_req && !mem_rd && !mem_wr && !dev_ack;
        if ((mem_rd || mem_wr || dev_ack) && !(bus_grant && bus_req)) bad = 1;
        if (dev_ack && !dev_req) bad = 1;
        if (mem_rd !== (dev_ack & dir) || mem_wr !== (dev_ack & ~dir)) bad = 1;
        if (!bus_req) lows++;
        if (bus_req && !prev_br) tenures++;
        prev_br = bus_req;
        if (dev_ack) begin
          acks++;
          if (acks == n) pend = 1;
        end
      end
      @(negedge clk);
    end
    dev_req = 0;
    chk(fin, "R9 block completed", fin, 1);
    chk(first_ok, "R2 bus_req next cycle, no strobe before grant", first_ok, 1);
    chk(!bad, "R5/R8 strobes only with grant and dev_req, direction correct", bad, 0);
    chk(acks == n, "R8 one acknowledge per word", acks, n);
    chk(tenures == (steal ? n : 1), steal ? "R7 tenures per word" : "R6 single tenure", tenures, steal ? n : 1);
    chk(lows == (steal ? n - 1 : 0), steal ? "R7 one-cycle release per word" : "R6 request held", lows, steal ? n - 1 : 0);
    for (int i = 0; i < n; i++) begin
      if (dir) chk(sink[i] == DW'(16'h5000 + start + i), "R8 memory to peripheral data", sink[i], 16'h5000 + start + i);
      else     chk(mem[start + i] == DW'(16'hA000 + i), "R8 peripheral to memory data", mem[start + i], 16'hA000 + i);
    end
    chk(mem[start + n] == DW'(16'h5000 + start + n), "R3 word past block untouched", mem[start + n], 16'h5000 + start + n);
    repeat (3) @(negedge clk);
    #1 chk(irq == 1'b1, "R9 irq held", irq, 1);
    cfg_read(2'd0, rv); chk(rv == DW'(start + n), "R3 final address", rv, start + n);
    cfg_read(2'd1, rv); chk(rv == 0, "R4 count at zero", rv, 0);
    cfg_read(2'd2, rv); chk(rv == DW'({1'b1, steal, dir, 1'b0}), "R1 status done", rv, {1'b1, steal, dir, 1'b0});
    cfg_write(2'd2, 0);
    #1 chk(irq == 1'b0, "R9 control write clears irq", irq, 0);
  endtask

  initial begin
    logic [DW-1:0] rv;
    bit br_seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk({bus_req, irq, mem_rd, mem_wr, dev_ack} == 0, "R13 outputs low after reset",
           {bus_req, irq, mem_rd, mem_wr, dev_ack}, 0);
    for (int r = 0; r < 3; r++) begin
      cfg_read(2'(r), rv); chk(rv == 0, "R13 register zero after reset", rv, 0);
    end

    cfg_write(2'd0, 16'h0005);
    cfg_read(2'd3, rv); chk(rv == 0, "R1 index 3 reads zero", rv, 0);
    @(negedge clk); reg_sel = 1; reg_idx = 0; #1;
    chk(reg_rdata == 0, "R1 rdata zero without read", reg_rdata, 0);
    reg_sel = 0;
    cfg_read(2'd0, rv); chk(rv == 16'h0005, "R1 address readback", rv, 5);

    for (int v = 0; v < NV; v++) run_vec(V_START[v], V_CNT[v], V_DIR[v], V_STEAL[v], V_GAP[v]);

    cfg_write(2'd1, 0);
    cfg_write(2'd2, 16'h0001);
    #1 chk(irq && !bus_req, "R11 zero count completes at once", {irq, bus_req}, 2'b10);
    br_seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1 if (bus_req) br_seen = 1;
    end
    chk(!br_seen, "R11 no bus request for zero count", br_seen, 0);
    cfg_read(2'd2, rv); chk(rv == 16'h0008, "R11 status done not busy", rv, 8);
    cfg_write(2'd2, 0);

    allow_grant = 0;
    @(negedge clk); mem_load = 1; dev_clr = 1;
    @(negedge clk); mem_load = 0; dev_clr = 0;
    cfg_write(2'd0, 16'd40);
    cfg_write(2'd1, 16'd2);
    cfg_write(2'd2, 16'h0001);
    dev_req = 1;
    repeat (3) @(negedge clk);
    #1 chk(bus_req == 1'b1, "R2 request held while grant withheld", bus_req, 1);
    chk({mem_wr, mem_rd, dev_ack} == 0, "R2 no strobe without grant", {mem_wr, mem_rd, dev_ack}, 0);
    cfg_write(2'd0, 16'd7);
    cfg_write(2'd1, 16'd9);
    cfg_read(2'd0, rv); chk(rv == 16'd40, "R12 address write ignored while busy", rv, 40);
    cfg_read(2'd1, rv); chk(rv == 16'd2, "R12 count write ignored while busy", rv, 2);
    cfg_read(2'd2, rv); chk(rv == 16'h0001, "R12 status busy", rv, 1);
    allow_grant = 1;
    for (int i = 0; i < 20 && !irq; i++) @(negedge clk);
    #1 chk(irq == 1'b1, "R12 transfer finishes after grant", irq, 1);
    dev_req = 0;
    cfg_read(2'd0, rv); chk(rv == 16'd42, "R3 address after delayed grant", rv, 42);
    chk(mem[40] == 16'hA000 && mem[41] == 16'hA001, "R8 data after delayed grant", mem[41], 16'hA001);
    cfg_write(2'd2, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule